// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM

This block is a synthesizable model of a single-clock synchronous static RAM. It accepts a read or a write on every enabled clock edge, with no dead cycle when the bus direction changes. Address, control and byte enables are registered on the rising edge. Read data flows through: the word for a registered read address appears during the cycle after that edge, through a combinational access path. Write data arrives one enabled edge after its address. It is parked in a pending-write register and written into the array when the next write data arrives. A read that hits the pending address is served from that register, so reads always return the newest data.

A load cycle starts a new access when all three chip enables are active. An advance cycle continues the previous read or write through a four-beat wrapping burst, in linear or interleaved order. An active-low clock enable freezes every register for a cycle. A sleep input shuts off new operations and the output drive while keeping the contents. The data bus is modelled as separate input and output ports plus a drive flag. An asynchronous output enable gates that flag, and so do write cycles and idle cycles.

Top module: `zt_sram`

## Requirements
- R1: After reset the output is not driven, and every word reads as zero.
- R2: A load cycle (`advance`=0) selects the device only when `ce_a_n`=0, `ce_b`=1 and `ce_c_n`=0. Otherwise the following cycle is idle and the output is not driven.
- R3: At a selected load edge, `we_n`=0 registers a write and `we_n`=1 registers a read. The read word appears on `rdata` in the cycle right after that edge. The data of a write is taken from `wdata` at the next enabled edge. Reads and writes may alternate on every edge with no idle cycle.
- R4: A read of the address whose write data was captured most recently, and not yet stored in the array, returns that data for the lanes that write enabled. It returns the array contents for the other lanes.
- R5: Lane i covers bits [9i+8:9i]. A write changes lane i only if `lane_we_n[i]`=0 was sampled with its address. All other lanes keep their stored value.
- R6: With `interleave`=0, advance cycles continue the previous read or write. Beat k uses low address bits (base+k) mod 4, and the upper address bits stay unchanged.
- R7: With `interleave`=1, beat k of a burst uses low address bits base XOR k.
- R8: An advance cycle that follows an idle cycle stays idle.
- R9: While `clk_en_n`=1 at an edge, no register changes. The output stays the same, and the data capture of a pending write moves to the next enabled edge.
- R10: While `sleep`=1, the output drive is off at once. Load and advance cycles are ignored, and the array keeps its contents. A write whose address was already accepted still captures its data.
- R11: `rdata_oe` is 1 only in a read cycle with `oe_n`=0 and `sleep`=0, and it follows `oe_n` without a clock edge. `rdata` is zero whenever `rdata_oe` is 0.
- R12: The output is never driven in a write cycle, whatever the value of `oe_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for all registers |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_en_n | input | 1 | Active-low clock enable; when high, all state holds |
| sleep | input | 1 | Power-down request; ignores operations and keeps contents |
| ce_a_n | input | 1 | Chip enable, active low |
| ce_b | input | 1 | Chip enable, active high |
| ce_c_n | input | 1 | Chip enable, active low |
| advance | input | 1 | 1 continues the burst, 0 loads a new access |
| we_n | input | 1 | Write enable, active low, sampled on load |
| lane_we_n | input | LANES | Per-lane write enables, active low |
| interleave | input | 1 | Burst order: 1 interleaved, 0 linear |
| oe_n | input | 1 | Asynchronous output enable, active low |
| addr | input | AW | Word address, sampled on load |
| wdata | input | LANES*LANE_W | Write data, sampled one enabled edge after its address |
| rdata | output | LANES*LANE_W | Read data, zero when not driven |
| rdata_oe | output | 1 | High when the output would drive the bus |

## Verification
The hardest case to reach is a read that lands on a write which has captured its data but is still parked outside the array. If only some of that write's lanes were enabled, the read word has to combine register data with array data. The stimulus issues a partial-lane write and then reads the same address on the next edge. It also puts a clock-enable stall and a sleep window between a write's address and its data. These sequences move the data capture to other edges and push the array store back behind the next write.

// File: rtl/zt_pkg.sv
package zt_pkg;
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;
endpackage

// File: rtl/zt_burst.sv
// Next burst address: keeps the upper bits and steps the low CW bits
// either by wrapping addition or by XOR with the beat count.
module zt_burst #(
    parameter int AW = 6,
    parameter int CW = 2
) (
    input  logic [AW-1:0] cur_addr,
    input  logic [CW-1:0] base_lo,
    input  logic [CW-1:0] beat,
    input  logic          interleave,
    output logic [AW-1:0] nxt_addr
);
    logic [CW-1:0] lo_lin;
    logic [CW-1:0] lo_ilv;

    always_comb begin
        lo_lin   = base_lo + beat;
        lo_ilv   = base_lo ^ beat;
        nxt_addr = {cur_addr[AW-1:CW], (interleave ? lo_ilv : lo_lin)};
    end
endmodule

// File: rtl/zt_store.sv
// Word array with a one-entry late-write register and a per-lane read bypass.
module zt_store #(
    parameter int AW     = 6,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cap_en,
    input  logic [AW-1:0]           cap_addr,
    input  logic [LANES*LANE_W-1:0] cap_data,
    input  logic [LANES-1:0]        cap_lanes,
    input  logic [AW-1:0]           rd_addr,
    output logic [LANES*LANE_W-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;
    localparam int DW    = LANES * LANE_W;

    typedef struct packed {
        logic             vld;
        logic [AW-1:0]    addr;
        logic [DW-1:0]    data;
        logic [LANES-1:0] lanes;
    } pend_t;

    pend_t         pend_d, pend_q;
    logic [DW-1:0] mem_q [DEPTH];
    logic          hit;

    always_comb begin
        pend_d = pend_q;
        if (cap_en) begin
            pend_d.vld   = 1'b1;
            pend_d.addr  = cap_addr;
            pend_d.data  = cap_data;
            pend_d.lanes = cap_lanes;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            pend_q <= pend_d;
            if (cap_en && pend_q.vld) begin
                for (int l = 0; l < LANES; l++) begin
                    if (pend_q.lanes[l]) begin
                        mem_q[pend_q.addr][l*LANE_W +: LANE_W] <= pend_q.data[l*LANE_W +: LANE_W];
                    end
                end
            end
        end
    end

    assign hit = pend_q.vld && (pend_q.addr == rd_addr);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign rd_data[g*LANE_W +: LANE_W] = (hit && pend_q.lanes[g])
                                           ? pend_q.data[g*LANE_W +: LANE_W]
                                           : mem_q[rd_addr][g*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/zt_sram.sv
module zt_sram #(
    parameter int AW     = 6,
    parameter int LANES  = 2,
    parameter int LANE_W = 9,
    parameter int CW     = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clk_en_n,
    input  logic                    sleep,
    input  logic                    ce_a_n,
    input  logic                    ce_b,
    input  logic                    ce_c_n,
    input  logic                    advance,
    input  logic                    we_n,
    input  logic [LANES-1:0]        lane_we_n,
    input  logic                    interleave,
    input  logic                    oe_n,
    input  logic [AW-1:0]           addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rdata_oe
);
    import zt_pkg::*;

    localparam int DW = LANES * LANE_W;

    typedef struct packed {
        op_e              op;
        logic [AW-1:0]    addr;
        logic [CW-1:0]    base;
        logic [CW-1:0]    beat;
        logic [LANES-1:0] lanes;
    } cyc_t;

    cyc_t          st_d, st_q;
    logic          chip_sel;
    logic          cap_en;
    logic [CW-1:0] beat_inc;
    logic [AW-1:0] burst_addr;
    logic [DW-1:0] arr_rd;

    assign chip_sel = !ce_a_n && ce_b && !ce_c_n;
    assign beat_inc = st_q.beat + 1'b1;

    zt_burst #(.AW(AW), .CW(CW)) u_burst (
        .cur_addr   (st_q.addr),
        .base_lo    (st_q.base),
        .beat       (beat_inc),
        .interleave (interleave),
        .nxt_addr   (burst_addr)
    );

    always_comb begin
        st_d   = st_q;
        cap_en = 1'b0;
        if (!clk_en_n) begin
            // data phase of an accepted write completes even during sleep
            cap_en = (st_q.op == OP_WRITE);
            if (sleep) begin
                st_d.op = OP_IDLE;
            end else if (advance) begin
                if (st_q.op != OP_IDLE) begin
                    st_d.beat  = beat_inc;
                    st_d.addr  = burst_addr;
                    st_d.lanes = ~lane_we_n;
                end
            end else if (chip_sel) begin
                st_d.op    = we_n ? OP_READ : OP_WRITE;
                st_d.addr  = addr;
                st_d.base  = addr[CW-1:0];
                st_d.beat  = '0;
                st_d.lanes = ~lane_we_n;
            end else begin
                st_d.op = OP_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.op    <= OP_IDLE;
            st_q.addr  <= '0;
            st_q.base  <= '0;
            st_q.beat  <= '0;
            st_q.lanes <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    zt_store #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_en    (cap_en),
        .cap_addr  (st_q.addr),
        .cap_data  (wdata),
        .cap_lanes (st_q.lanes),
        .rd_addr   (st_q.addr),
        .rd_data   (arr_rd)
    );

    assign rdata_oe = (st_q.op == OP_READ) && !oe_n && !sleep;
    assign rdata    = rdata_oe ? arr_rd : '0;
endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk #(
    parameter int DW = 18
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clk_en_n,
    input logic          sleep,
    input logic          ce_a_n,
    input logic          ce_b,
    input logic          ce_c_n,
    input logic          advance,
    input logic          we_n,
    input logic          oe_n,
    input logic [DW-1:0] rdata,
    input logic          rdata_oe
);
    logic sel_in;
    assign sel_in = !ce_a_n && ce_b && !ce_c_n;

    // R2
    deselect_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!clk_en_n && !sleep && !advance && !sel_in) |-> !rdata_oe);

    // R12
    write_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!clk_en_n && !sleep && !advance && sel_in && !we_n) |-> !rdata_oe);

    // R10
    sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !rdata_oe);

    // R11
    undriven_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rdata_oe |-> (rdata == '0));

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(clk_en_n) && $stable(oe_n) && $stable(sleep)) |-> ($stable(rdata) && $stable(rdata_oe)));
endmodule

bind zt_sram zt_sram_chk #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_en_n (clk_en_n),
    .sleep    (sleep),
    .ce_a_n   (ce_a_n),
    .ce_b     (ce_b),
    .ce_c_n   (ce_c_n),
    .advance  (advance),
    .we_n     (we_n),
    .oe_n     (oe_n),
    .rdata    (rdata),
    .rdata_oe (rdata_oe)
);

// File: tb/zt_sram_bench.sv
`timescale 1ns/1ps
module zt_sram_bench;
    localparam int AW = 6, LANES = 2, LANE_W = 9, DW = LANES * LANE_W, DEPTH = 1 << AW;

    logic clk = 1'b0, rst_n = 1'b0;
    logic clk_en_n = 1'b0, sleep = 1'b0, ce_a_n = 1'b1, ce_b = 1'b0, ce_c_n = 1'b1;
    logic advance = 1'b0, we_n = 1'b1, interleave = 1'b0, oe_n = 1'b0;
    logic [LANES-1:0] lane_we_n = '1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic rdata_oe;

    always #4 clk = ~clk;

    zt_sram #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_zt_sram (
        .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .sleep(sleep),
        .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n), .advance(advance),
        .we_n(we_n), .lane_we_n(lane_we_n), .interleave(interleave), .oe_n(oe_n),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
    );

    int checks = 0, bad = 0, cyc = 0;
    bit done = 0;
    string tag = "R1";
    logic [31:0] seed = 32'h1234_5678;

    // behavioural reference state
    logic [DW-1:0] mm [DEPTH];
    int m_op = 0;               // 0 idle, 1 read, 2 write
    int m_addr = 0, m_base = 0, m_beat = 0;
    logic [LANES-1:0] m_lanes = '0;
    bit p_v = 0;
    int p_a = 0;
    logic [DW-1:0] p_d = '0;
    logic [LANES-1:0] p_l = '0;

    function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] nw, logic [LANES-1:0] m);
        logic [DW-1:0] r = old;
        for (int l = 0; l < LANES; l++)
            if (m[l]) r[l*LANE_W +: LANE_W] = nw[l*LANE_W +: LANE_W];
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mm[i] = '0;
            m_op = 0; p_v = 0; m_addr = 0; m_base = 0; m_beat = 0;
        end else if (!clk_en_n) begin
            if (m_op == 2) begin
                if (p_v) mm[p_a] = merge(mm[p_a], p_d, p_l);
                p_v = 1; p_a = m_addr; p_d = wdata; p_l = m_lanes;
            end
            if (sleep) m_op = 0;
            else if (advance) begin
                if (m_op != 0) begin
                    int off;
                    m_beat = (m_beat + 1) % 4;
                    off = interleave ? (m_base ^ m_beat) : ((m_base + m_beat) % 4);
                    m_addr = (m_addr / 4) * 4 + off;
                    m_lanes = ~lane_we_n;
                end
            end else if (!ce_a_n && ce_b && !ce_c_n) begin
                m_op = we_n ? 1 : 2;
                m_addr = int'(addr); m_base = m_addr % 4; m_beat = 0;
                m_lanes = ~lane_we_n;
            end else m_op = 0;
        end
    end

    task automatic compare();
        logic exp_oe;
        logic [DW-1:0] exp_d;
        exp_oe = (m_op == 1) && !oe_n && !sleep;
        exp_d = '0;
        if (exp_oe) begin
            exp_d = mm[m_addr];
            if (p_v && p_a == m_addr) exp_d = merge(exp_d, p_d, p_l);
        end
        checks++;
        if (rdata_oe !== exp_oe || rdata !== exp_d) begin
            bad++;
            $display("FAIL %s t=%0t actual oe=%b data=%h expected oe=%b data=%h",
                     tag, $time, rdata_oe, rdata, exp_oe, exp_d);
        end
    endtask

    task automatic tick();
        seed = seed * 32'd1103515245 + 32'd12345;
        wdata = seed[DW+7:8];
        @(posedge clk);
        #2;
        compare();
    endtask

    task automatic load(bit wr, int a, logic [LANES-1:0] ln);
        advance = 0; ce_a_n = 0; ce_b = 1; ce_c_n = 0;
        we_n = !wr; addr = AW'(a); lane_we_n = ~ln;
        tick();
    endtask

    task automatic adv(logic [LANES-1:0] ln);
        advance = 1; lane_we_n = ~ln;
        tick();
    endtask

    task automatic nop();
        advance = 0; ce_a_n = 1; we_n = 1;
        tick();
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            bad++;
            $display("FAIL watchdog (all requirements) actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #2 rst_n = 1;
        tag = "R1"; nop(); load(0, 0, 2'b11); load(0, 1, 2'b11); load(0, 63, 2'b11); nop();

        tag = "R3";
        load(1, 5, 2'b11); load(0, 10, 2'b11); load(1, 6, 2'b11); load(0, 5, 2'b11);
        load(1, 10, 2'b11); load(0, 6, 2'b11); load(0, 10, 2'b11); nop();

        tag = "R4";
        load(1, 9, 2'b11); load(0, 9, 2'b11); load(1, 9, 2'b01); load(0, 9, 2'b11); nop(); load(0, 9, 2'b11);

        tag = "R5";
        load(1, 20, 2'b10); nop(); load(1, 21, 2'b00); load(0, 20, 2'b11); load(0, 21, 2'b11);
        load(1, 5, 2'b01); load(1, 40, 2'b11); load(0, 5, 2'b11); nop();

        tag = "R6"; interleave = 0;
        load(1, 30, 2'b11); adv(2'b11); adv(2'b10); adv(2'b11); nop();
        load(0, 30, 2'b11); adv(0); adv(0); adv(0); adv(0); nop();

        tag = "R7"; interleave = 1;
        load(1, 45, 2'b11); adv(2'b11); adv(2'b11); adv(2'b01); nop();
        load(0, 45, 2'b11); adv(0); adv(0); adv(0); nop();
        interleave = 0; load(0, 44, 2'b11); adv(0); adv(0); adv(0); nop();

        tag = "R8"; nop(); adv(2'b11); adv(2'b11); nop();

        tag = "R2";
        ce_a_n = 1; ce_b = 1; ce_c_n = 0; advance = 0; we_n = 1; addr = 5; tick();
        ce_a_n = 0; ce_b = 0; ce_c_n = 0; tick();
        ce_a_n = 0; ce_b = 1; ce_c_n = 1; tick();
        ce_a_n = 0; ce_b = 0; ce_c_n = 0; we_n = 0; lane_we_n = '0; addr = 5; tick();
        load(0, 5, 2'b11);

        tag = "R9";
        load(1, 12, 2'b11);
        clk_en_n = 1; tick(); tick();
        clk_en_n = 0; load(0, 12, 2'b11);
        clk_en_n = 1; tick(); tick();
        clk_en_n = 0; nop(); load(0, 12, 2'b11);

        tag = "R10";
        load(1, 50, 2'b11);
        sleep = 1; load(1, 5, 2'b11); load(0, 50, 2'b11); adv(2'b11);
        #1 compare();
        sleep = 0; nop(); load(0, 50, 2'b11); load(0, 5, 2'b11);
        sleep = 1; #1 compare(); sleep = 0; #1 compare();
        nop();

        tag = "R11";
        load(0, 12, 2'b11);
        oe_n = 1; #1 compare(); oe_n = 0; #1 compare();
        oe_n = 1; tick(); load(0, 6, 2'b11); oe_n = 0; #1 compare(); nop();

        tag = "R12";
        oe_n = 0; load(1, 33, 2'b11); load(1, 34, 2'b10); load(0, 33, 2'b11);
        load(1, 33, 2'b11); adv(2'b11); nop(); load(0, 34, 2'b11); nop();

        done = 1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule